// File: doc/BRIEF.md
# Gated Selectable-Source Clock Divider Channel

This block derives two related clocks from one of four parent sources. A 2-bit selector chooses the parent. An integer divider with a ratio from 1 to 16 produces the primary output. The secondary output is either a copy of the primary or the primary divided by two once more. Each output has its own enable bit. All settings live in one 32-bit control word, which is written and read through a plain register port.

Everything runs in a single reference clock domain. Each parent is modelled as a one-cycle enable pulse, or "tick", on that reference clock. The outputs are registered levels that change only when the selected parent ticks; the one exception is ratio 1, where the primary output is a one-cycle copy of each tick.

Settings are applied without glitches. A new ratio, halving choice or parent selection takes effect only where an output period ends. An enable change reaches an output only while that output is low.

Top module: `pixclk_chan`

## Requirements
- R1: After reset the control word reads 0 (parent 0, ratio 1, halving off), both clock outputs are low and `chan_active_o` is low.
- R2: Only these bits are stored and read back exactly as written: primary enable bit 31, parent select bits 25:24, secondary enable bit 15, halving bit 11 and divider bits 3:0. Every other bit reads 0 and writes to it are ignored.
- R3: `chan_active_o` is high whenever bit 31 or bit 15 of the stored word is set, and low when both are clear.
- R4: Parent select value k (0..3) makes `src_tick[k]` the counted source. With divider field D, the primary output has a period of exactly D+1 selected ticks and changes only on the cycle after a selected tick.
- R5: For a ratio N = D+1 of 2 or more, the primary output is high for floor(N/2) ticks of each period, which gives a 50% duty cycle for even N. For N = 1 it is a one-reference-cycle high pulse after each selected tick.
- R6: With the halving bit set, the secondary output has period 2N ticks and is high for N of them, toggling on each primary rising edge. With the halving bit clear, the secondary output equals the primary output.
- R7: A write that changes the divider, halving or parent fields does not alter the output period in progress. The new values, and a restarted tick counter, start at the next period boundary: the selected tick that ends the current period.
- R8: Bit 31 gates the primary output and bit 15 gates the secondary output. A gated-off output stays low. An enable change takes effect only while the ungated output is low, so a high phase is never cut short and never starts partway through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Stored control word, reserved bits zero |
| src_tick | input | 4 | One enable pulse input per parent source |
| pri_clk_o | output | 1 | Gated primary divided clock |
| sec_clk_o | output | 1 | Gated secondary clock, optionally halved |
| chan_active_o | output | 1 | High while either output enable bit is set |

## Verification
The hardest situation to reach is a control write that lands inside an output period, especially while an output is high. There the deferred ratio update and the deferred gate must both hold off. The bench watches the output at its ports until it sees a rising edge, then issues the write in that same cycle. It then measures the length of the high phase in progress and of the periods that follow. The ratio and duty checks use parents with different tick spacings, so that a mis-selected source shows up as a wrong period.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_SRC    = 4;
  localparam int SEL_W      = $clog2(NUM_SRC);
  localparam int DIV_W      = 4;
  localparam int PRI_EN_BIT = 31;
  localparam int SEL_LSB    = 24;
  localparam int SEC_EN_BIT = 15;
  localparam int HALF_BIT   = 11;
  localparam int DIV_LSB    = 0;

  localparam logic [REG_W-1:0] RW_MASK =
      (REG_W'(1) << PRI_EN_BIT) |
      (REG_W'((1 << SEL_W) - 1) << SEL_LSB) |
      (REG_W'(1) << SEC_EN_BIT) |
      (REG_W'(1) << HALF_BIT) |
      (REG_W'((1 << DIV_W) - 1) << DIV_LSB);

  typedef struct packed {
    logic             pri_en;
    logic             sec_en;
    logic [SEL_W-1:0] sel;
    logic             half;
    logic [DIV_W-1:0] div;
  } chan_cfg_t;
endpackage

// File: rtl/pixclk_cfg.sv
module pixclk_cfg
  import pixclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output chan_cfg_t        cfg_o,
  output logic [REG_W-1:0] rd_data
);
  chan_cfg_t cfg_q, cfg_n;
  logic      unused_wr_bits;

  assign unused_wr_bits = ^(wr_data & ~RW_MASK);

  always_comb begin
    cfg_n = cfg_q;
    if (wr_en) begin
      cfg_n.pri_en = wr_data[PRI_EN_BIT];
      cfg_n.sec_en = wr_data[SEC_EN_BIT];
      cfg_n.sel    = wr_data[SEL_LSB +: SEL_W];
      cfg_n.half   = wr_data[HALF_BIT];
      cfg_n.div    = wr_data[DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[PRI_EN_BIT]          = cfg_q.pri_en;
    rd_data[SEC_EN_BIT]          = cfg_q.sec_en;
    rd_data[SEL_LSB +: SEL_W]    = cfg_q.sel;
    rd_data[HALF_BIT]            = cfg_q.half;
    rd_data[DIV_LSB +: DIV_W]    = cfg_q.div;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pixclk_div_core.sv
module pixclk_div_core #(
  parameter int NSRC = 4,
  parameter int SW   = 2,
  parameter int DW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic [SW-1:0]   sel_req,
  input  logic [DW-1:0]   div_req,
  input  logic            half_req,
  output logic            tick_sel,
  output logic            boundary,
  output logic            pri_raw,
  output logic            sec_raw,
  output logic [DW-1:0]   act_div,
  output logic [DW-1:0]   cnt_cur,
  output logic            act_half,
  output logic [SW-1:0]   act_sel
);
  localparam int LW = DW + 1;

  logic [DW-1:0] div_q, div_n, cnt_q, cnt_n;
  logic [SW-1:0] sel_q, sel_n;
  logic          half_q, half_n, tff_q, tff_n;
  logic          pri_q, pri_n, sec_q, sec_n;
  logic [LW-1:0] hi_len;

  assign tick_sel = src_tick[sel_q];
  assign boundary = tick_sel && (cnt_q == div_q);

  always_comb begin
    div_n  = div_q;
    half_n = half_q;
    sel_n  = sel_q;
    cnt_n  = cnt_q;
    tff_n  = tff_q;
    pri_n  = pri_q;
    if (tick_sel) begin
      if (boundary) begin
        div_n  = div_req;
        half_n = half_req;
        sel_n  = sel_req;
        cnt_n  = '0;
        tff_n  = ~tff_q;
      end else begin
        cnt_n  = cnt_q + 1'b1;
      end
    end
    if (div_n == '0) hi_len = LW'(1);
    else             hi_len = (LW'(div_n) + LW'(1)) >> 1;
    if (tick_sel)            pri_n = (LW'(cnt_n) < hi_len);
    else if (div_q == '0)    pri_n = 1'b0;
    sec_n = half_n ? tff_n : pri_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      half_q <= 1'b0;
      sel_q  <= '0;
      cnt_q  <= '0;
      tff_q  <= 1'b0;
      pri_q  <= 1'b0;
      sec_q  <= 1'b0;
    end else begin
      div_q  <= div_n;
      half_q <= half_n;
      sel_q  <= sel_n;
      cnt_q  <= cnt_n;
      tff_q  <= tff_n;
      pri_q  <= pri_n;
      sec_q  <= sec_n;
    end
  end

  assign pri_raw  = pri_q;
  assign sec_raw  = sec_q;
  assign act_div  = div_q;
  assign cnt_cur  = cnt_q;
  assign act_half = half_q;
  assign act_sel  = sel_q;
endmodule

// File: rtl/pixclk_gate.sv
module pixclk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic raw_i,
  output logic en_eff,
  output logic clk_o
);
  logic en_q, en_n;

  always_comb begin
    en_n = en_q;
    if (!raw_i) en_n = en_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_n;
  end

  assign en_eff = en_q;
  assign clk_o  = raw_i & en_q;
endmodule

// File: rtl/pixclk_chan.sv
module pixclk_chan
  import pixclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               pri_clk_o,
  output logic               sec_clk_o,
  output logic               chan_active_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  chan_cfg_t        cfg;
  logic             tick_sel, boundary, pri_raw, sec_raw, act_half;
  logic [DIV_W-1:0] act_div, cnt_cur;
  logic [SEL_W-1:0] act_sel;
  logic [1:0]       raw_v, req_v, gate_eff, out_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pixclk_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg_o   (cfg),
    .rd_data (rd_data)
  );

  pixclk_div_core #(.NSRC(NUM_SRC), .SW(SEL_W), .DW(DIV_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .src_tick (src_tick),
    .sel_req  (cfg.sel),
    .div_req  (cfg.div),
    .half_req (cfg.half),
    .tick_sel (tick_sel),
    .boundary (boundary),
    .pri_raw  (pri_raw),
    .sec_raw  (sec_raw),
    .act_div  (act_div),
    .cnt_cur  (cnt_cur),
    .act_half (act_half),
    .act_sel  (act_sel)
  );

  assign raw_v = {sec_raw, pri_raw};
  assign req_v = {cfg.sec_en, cfg.pri_en};

  for (genvar g = 0; g < 2; g++) begin : g_gate
    pixclk_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .en_req (req_v[g]),
      .raw_i  (raw_v[g]),
      .en_eff (gate_eff[g]),
      .clk_o  (out_v[g])
    );
  end

  assign pri_clk_o     = out_v[0];
  assign sec_clk_o     = out_v[1];
  assign chan_active_o = cfg.pri_en | cfg.sec_en;
endmodule

// File: rtl/pixclk_chan_chk.sv
module pixclk_chan_chk
  import pixclk_pkg::*;
(
  input logic             clk,
  input logic             rst_core_n,
  input logic [REG_W-1:0] rd_data,
  input logic             tick_sel,
  input logic             boundary,
  input logic             pri_raw,
  input logic [DIV_W-1:0] act_div,
  input logic [DIV_W-1:0] cnt_cur,
  input logic             act_half,
  input logic [SEL_W-1:0] act_sel,
  input logic [1:0]       gate_eff,
  input logic [1:0]       raw_v
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_data & ~RW_MASK) == '0);

  p_rise_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(pri_raw) |-> $past(tick_sel));

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    cnt_cur <= act_div);

  p_ratio_hold_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !boundary |=> ($stable(act_div) && $stable(act_half) && $stable(act_sel)));

  p_pri_gate_low_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(gate_eff[0]) |-> !$past(raw_v[0]));

  p_sec_gate_low_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(gate_eff[1]) |-> !$past(raw_v[1]));
endmodule

bind pixclk_chan pixclk_chan_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .rd_data    (rd_data),
  .tick_sel   (tick_sel),
  .boundary   (boundary),
  .pri_raw    (pri_raw),
  .act_div    (act_div),
  .cnt_cur    (cnt_cur),
  .act_half   (act_half),
  .act_sel    (act_sel),
  .gate_eff   (gate_eff),
  .raw_v      (raw_v)
);

// File: tb/sim_pixclk_chan.sv
`timescale 1ns/1ps
module sim_pixclk_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  src_tick;
  logic        pri_clk_o, sec_clk_o, chan_active_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // tick spacing of each parent, in reference cycles
  localparam int SP[4] = '{2, 3, 1, 4};
  // sel, div, half, pri period, pri high, sec period, sec high
  localparam int VEC[8][7] = '{
    '{0,  3, 0,  8, 4,  8,  4},
    '{1,  4, 1, 15, 6, 30, 15},
    '{2,  6, 0,  7, 3,  7,  3},
    '{3,  0, 1,  4, 1,  8,  4},
    '{2, 15, 1, 16, 8, 32, 16},
    '{0,  1, 0,  4, 2,  4,  2},
    '{1,  0, 0,  3, 1,  3,  1},
    '{3,  2, 1, 12, 4, 24, 12}
  };

  pixclk_chan u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .src_tick(src_tick), .pri_clk_o(pri_clk_o), .sec_clk_o(sec_clk_o),
    .chan_active_o(chan_active_o)
  );

  always #2 clk = ~clk;

  initial begin
    int ph[4];
    src_tick = '0;
    for (int k = 0; k < 4; k++) ph[k] = 0;
    forever begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        src_tick[k] = (ph[k] == 0);
        ph[k] = (ph[k] + 1) % SP[k];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] word(input bit pe, input bit se, input int sel,
                                       input bit hf, input int dv);
    return (32'(pe) << 31) | (32'(sel) << 24) | (32'(se) << 15) | (32'(hf) << 11) | 32'(dv);
  endfunction

  function automatic logic sig(input int which);
    return (which == 1) ? sec_clk_o : pri_clk_o;
  endfunction

  task automatic wait_rise(input int which, output bit ok);
    logic prev, cur;
    ok = 0;
    prev = sig(which);
    for (int g = 0; g < 3000; g++) begin
      @(negedge clk);
      cur = sig(which);
      if (!prev && cur) begin ok = 1; break; end
      prev = cur;
    end
  endtask

  task automatic meas(input int which, output int per, output int hi);
    bit ok;
    logic prev, cur;
    per = -1; hi = -1;
    wait_rise(which, ok);
    if (ok) begin
      per = 1; hi = 1; prev = 1'b1;
      for (int g = 0; g < 3000; g++) begin
        @(negedge clk);
        cur = sig(which);
        if (!prev && cur) break;
        per++;
        if (cur) hi++;
        prev = cur;
      end
    end
  endtask

  initial begin
    int per, hi, rises;
    bit ok;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(rd_data == 32'h0, "R1 rd_data", rd_data, 0);
    chk(pri_clk_o == 1'b0, "R1 pri_clk_o", pri_clk_o, 0);
    chk(sec_clk_o == 1'b0, "R1 sec_clk_o", sec_clk_o, 0);
    chk(chan_active_o == 1'b0, "R1 chan_active_o", chan_active_o, 0);
    rises = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (pri_clk_o || sec_clk_o) rises++;
    end
    chk(rises == 0, "R1 outputs stay low", rises, 0);

    // R2 readback and reserved bits
    wr(32'hFFFF_FFFF);
    chk(rd_data == 32'h8300_880F, "R2 all ones", rd_data, 32'h8300_880F);
    wr(32'h7CFF_77F0);
    chk(rd_data == 32'h0, "R2 reserved only", rd_data, 0);
    wr(32'h0200_0805);
    chk(rd_data == 32'h0200_0805, "R2 mixed fields", rd_data, 32'h0200_0805);

    // R3 active flag
    wr(word(0, 1, 0, 0, 1));
    chk(chan_active_o == 1'b1, "R3 sec only", chan_active_o, 1);
    wr(word(1, 0, 0, 0, 1));
    chk(chan_active_o == 1'b1, "R3 pri only", chan_active_o, 1);
    wr(word(0, 0, 0, 0, 1));
    chk(chan_active_o == 1'b0, "R3 none", chan_active_o, 0);

    // R4 R5 R6 table walk
    for (int i = 0; i < 8; i++) begin
      wr(word(1, 1, VEC[i][0], VEC[i][2] != 0, VEC[i][1]));
      repeat (300) @(negedge clk);
      meas(0, per, hi);
      chk(per == VEC[i][3], "R4 primary period", per, VEC[i][3]);
      chk(hi == VEC[i][4], "R5 primary high", hi, VEC[i][4]);
      meas(1, per, hi);
      chk(per == VEC[i][5], "R6 secondary period", per, VEC[i][5]);
      chk(hi == VEC[i][6], "R6 secondary high", hi, VEC[i][6]);
    end

    // R7 mid-period ratio change: parent 2 (every cycle), ratio 16 -> 2
    wr(word(1, 1, 2, 0, 15));
    repeat (100) @(negedge clk);
    wait_rise(0, ok);
    wr_en = 1'b1; wr_data = word(1, 1, 2, 0, 1);
    hi = 1;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (pri_clk_o) hi++; else break;
    end
    chk(ok && hi == 8, "R7 current high phase kept", hi, 8);
    meas(0, per, hi);
    chk(per == 2, "R7 new period", per, 2);
    chk(hi == 1, "R7 new high", hi, 1);

    // R8 gating: primary off, secondary on
    wr(word(0, 1, 0, 0, 3));
    repeat (50) @(negedge clk);
    rises = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (pri_clk_o) rises++;
    end
    chk(rises == 0, "R8 gated primary low", rises, 0);
    meas(1, per, hi);
    chk(per == 8 && hi == 4, "R8 secondary runs", per, 8);
    // enable primary: first pulse must be whole
    wr(word(1, 1, 0, 0, 3));
    wait_rise(0, ok);
    hi = 1;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (pri_clk_o) hi++; else break;
    end
    chk(ok && hi == 4, "R8 first pulse full", hi, 4);
    // disable during a high phase: pulse still completes
    wait_rise(0, ok);
    wr_en = 1'b1; wr_data = word(0, 1, 0, 0, 3);
    hi = 1;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (pri_clk_o) hi++; else break;
    end
    chk(ok && hi == 4, "R8 last pulse full", hi, 4);
    rises = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (pri_clk_o) rises++;
    end
    chk(rises == 0, "R8 stays low after gate", rises, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule